// File: doc/BRIEF.md
# Neuron-to-PE Range Mapper

This block works out which processing elements (PEs) of a neural network array compute a given neuron of a layer. A request carries the PE count of the array, the neuron count of the layer and the index of one neuron. The layer runs in rounds. Every full round has one neuron on each PE. The neurons left over for the final round share out the PEs: each gets an equal, contiguous slice, and any PEs that do not divide evenly sit idle. The block returns the inclusive low and high PE IDs of the slice, the round the neuron runs in, and a flag that is set when the neuron's weighted sum is split over more than one PE.

All arithmetic goes through one shared restoring divider that produces one quotient bit per cycle. A controller sequences up to three divisions: the neuron count by the PE count, the neuron index by the PE count, and the PE count by the residual count. The third division is skipped when the neuron sits in a full round or when the layer has no residual neurons. Controller states:
- `ST_IDLE`: waits for `start`.
- `ST_DIV_NP`: computes the full-round count and the residual.
- `ST_DIV_ID`: computes the round index and the position within the round.
- `ST_DIV_PR`: computes the PEs per residual neuron.
- `ST_FINISH`: latches the range.
- `ST_FAULT`: reports a malformed request.

Transitions:
- `ST_IDLE` goes to `ST_FAULT` on a bad request, or to `ST_DIV_NP` otherwise.
- `ST_DIV_NP` goes to `ST_DIV_ID` when the divider finishes.
- `ST_DIV_ID` goes to `ST_DIV_PR` when the neuron is residual, and to `ST_FINISH` otherwise.
- `ST_DIV_PR` goes to `ST_FINISH`.
- `ST_FINISH` and `ST_FAULT` both return to `ST_IDLE`.

Top module: `pe_range_mapper`

## Requirements
- R1: After reset `busy`, `done`, `err` and `intra` are 0, and `pe_lo`, `pe_hi` and `round_idx` are 0.
- R2: A `start` seen in idle makes `busy` 1 from the next cycle. `busy` stays 1 until `done` pulses high for exactly one cycle, and `busy` is 0 in that `done` cycle.
- R3: With Q = N / P and nid < Q·P (a full round), `pe_lo` = `pe_hi` = nid mod P.
- R4: With R = N mod P and nid ≥ Q·P (a residual neuron), the slice width is S = P / R. Then `pe_lo` = (nid mod P)·S and `pe_hi` = `pe_lo` + S − 1. PEs above R·S − 1 are never assigned.
- R5: `intra` is 1 exactly when `pe_hi` > `pe_lo`.
- R6: `round_idx` = nid / P.
- R7: When N is a multiple of P, every neuron of the layer gets a single PE.
- R8: A request with P = 0, N = 0 or nid ≥ N completes with `done` and `err` both 1, and with `pe_lo`, `pe_hi`, `round_idx` and `intra` all 0. `err` is cleared by the next accepted `start`.
- R9: A `start` that arrives while `busy` is 1 is ignored, and the request in flight completes with its own result.
- R10: The result outputs change only in a `done` cycle and hold their value until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, taken only in idle |
| pe_count | input | W | Number of PEs, P |
| neuron_count | input | W | Neurons in the layer, N |
| neuron_id | input | W | Neuron index, nid |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request was malformed |
| pe_lo | output | W | Lowest PE ID of the assigned range |
| pe_hi | output | W | Highest PE ID of the assigned range, inclusive |
| intra | output | 1 | Neuron is split over several PEs |
| round_idx | output | W | Round the neuron executes in |

## Verification
The range assertions assume that the PE count latched with an accepted request stays unchanged until its `done`. The design latches it on acceptance, and the stimulus changes the request inputs only while the block is idle or when it deliberately tests that a start during a busy period is ignored. The handshake assertions assume that `start` can arrive at any time. The directed requests include full rounds, residual neurons that split, residual neurons that do not split, layers that are exact multiples of the PE count, and malformed requests. Every expected value is computed from integer division in the bench.

// File: rtl/prm_pkg.sv
package prm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIV_NP,
        ST_DIV_ID,
        ST_DIV_PR,
        ST_FINISH,
        ST_FAULT
    } prm_state_e;

endpackage

// File: rtl/prm_divider.sv
// Restoring unsigned divider: one quotient bit per cycle, W cycles per division.
module prm_divider #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         fin,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  dvs_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic [W:0]    trial;
    logic [W:0]    diff;
    logic          qbit;
    logic [W-1:0]  rem_next;

    always_comb begin
        trial    = {rem, quo[W-1]};
        diff     = trial - {1'b0, dvs_q};
        qbit     = ~diff[W];
        rem_next = qbit ? diff[W-1:0] : trial[W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem   <= '0;
            quo   <= '0;
            dvs_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            fin   <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                rem   <= '0;
                quo   <= dividend;
                dvs_q <= divisor;
                cnt_q <= CW'(W);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem   <= rem_next;
                quo   <= {quo[W-2:0], qbit};
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    run_q <= 1'b0;
                    fin   <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/prm_range_calc.sv
// Turns the position within a round and the slice width into a PE range.
module prm_range_calc #(
    parameter int W = 8
) (
    input  logic [W-1:0] slot,
    input  logic [W-1:0] width,
    input  logic         split,
    output logic [W-1:0] lo,
    output logic [W-1:0] hi,
    output logic         multi
);
    logic [2*W-1:0] prod;
    logic [W-1:0]   base;

    always_comb begin
        prod  = {{W{1'b0}}, slot} * {{W{1'b0}}, width};
        base  = prod[W-1:0];
        lo    = split ? base : slot;
        hi    = split ? (base + width - {{(W-1){1'b0}}, 1'b1}) : slot;
        multi = hi > lo;
    end
endmodule

// File: rtl/pe_range_mapper.sv
module pe_range_mapper #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] pe_count,
    input  logic [W-1:0] neuron_count,
    input  logic [W-1:0] neuron_id,
    output logic         busy,
    output logic         done,
    output logic         err,
    output logic [W-1:0] pe_lo,
    output logic [W-1:0] pe_hi,
    output logic         intra,
    output logic [W-1:0] round_idx
);
    import prm_pkg::*;

    prm_state_e   state_q, state_d;
    logic [W-1:0] p_q, n_q, nid_q;
    logic [W-1:0] full_q, resid_q, rnd_q, slot_q, width_q;
    logic         split_q;
    logic         bad_req;
    logic         needs_split;

    logic         div_go, div_fin;
    logic [W-1:0] div_a, div_b, div_quo, div_rem;
    logic [W-1:0] calc_lo, calc_hi;
    logic         calc_multi;

    prm_divider #(.W(W)) i_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .dividend (div_a),
        .divisor  (div_b),
        .fin      (div_fin),
        .quo      (div_quo),
        .rem      (div_rem)
    );

    prm_range_calc #(.W(W)) i_calc (
        .slot  (slot_q),
        .width (width_q),
        .split (split_q),
        .lo    (calc_lo),
        .hi    (calc_hi),
        .multi (calc_multi)
    );

    assign bad_req     = (pe_count == '0) || (neuron_count == '0) || (neuron_id >= neuron_count);
    // Residual neuron: the layer has leftovers and this neuron's round is past the full ones.
    assign needs_split = (resid_q != '0) && (div_quo >= full_q);
    assign busy        = (state_q != ST_IDLE);

    // Divider launch and operand selection.
    always_comb begin
        div_go = 1'b0;
        div_a  = neuron_count;
        div_b  = pe_count;
        unique case (state_q)
            ST_IDLE: begin
                div_go = start && !bad_req;
            end
            ST_DIV_NP: begin
                div_go = div_fin;
                div_a  = nid_q;
                div_b  = p_q;
            end
            ST_DIV_ID: begin
                div_go = div_fin && needs_split;
                div_a  = p_q;
                div_b  = resid_q;
            end
            default: begin
                div_go = 1'b0;
            end
        endcase
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = bad_req ? ST_FAULT : ST_DIV_NP;
            ST_DIV_NP: if (div_fin) state_d = ST_DIV_ID;
            ST_DIV_ID: if (div_fin) state_d = needs_split ? ST_DIV_PR : ST_FINISH;
            ST_DIV_PR: if (div_fin) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            ST_FAULT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Working registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q     <= '0;
            n_q     <= '0;
            nid_q   <= '0;
            full_q  <= '0;
            resid_q <= '0;
            rnd_q   <= '0;
            slot_q  <= '0;
            width_q <= '0;
            split_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    p_q     <= pe_count;
                    n_q     <= neuron_count;
                    nid_q   <= neuron_id;
                    split_q <= 1'b0;
                end
                ST_DIV_NP: if (div_fin) begin
                    full_q  <= div_quo;
                    resid_q <= div_rem;
                end
                ST_DIV_ID: if (div_fin) begin
                    rnd_q   <= div_quo;
                    slot_q  <= div_rem;
                    split_q <= needs_split;
                end
                ST_DIV_PR: if (div_fin) width_q <= div_quo;
                default: ;
            endcase
        end
    end

    // Output registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done      <= 1'b0;
            err       <= 1'b0;
            pe_lo     <= '0;
            pe_hi     <= '0;
            intra     <= 1'b0;
            round_idx <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start) err <= 1'b0;
                ST_FINISH: begin
                    done      <= 1'b1;
                    pe_lo     <= calc_lo;
                    pe_hi     <= calc_hi;
                    intra     <= calc_multi;
                    round_idx <= rnd_q;
                end
                ST_FAULT: begin
                    done      <= 1'b1;
                    err       <= 1'b1;
                    pe_lo     <= '0;
                    pe_hi     <= '0;
                    intra     <= 1'b0;
                    round_idx <= '0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/prm_checker.sv
module prm_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic         err,
    input logic [W-1:0] pe_lo,
    input logic [W-1:0] pe_hi,
    input logic         intra,
    input logic [W-1:0] p_q
);
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_idle_at_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_range_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (pe_lo <= pe_hi) && (pe_hi < p_q));

    assert_fault_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (pe_lo == '0) && (pe_hi == '0) && !intra);

    assert_lo_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pe_lo) |-> done);

    assert_hi_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pe_hi) |-> done);
endmodule

bind pe_range_mapper prm_checker #(.W(W)) i_prm_checker (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .err   (err),
    .pe_lo (pe_lo),
    .pe_hi (pe_hi),
    .intra (intra),
    .p_q   (p_q)
);

// File: tb/test_pe_range_mapper.sv
module test_pe_range_mapper;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] pe_count = '0, neuron_count = '0, neuron_id = '0;
    logic         busy, done, err, intra;
    logic [W-1:0] pe_lo, pe_hi, round_idx;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    pe_range_mapper #(.W(W)) i_pe_range_mapper (
        .clk(clk), .rst_n(rst_n), .start(start),
        .pe_count(pe_count), .neuron_count(neuron_count), .neuron_id(neuron_id),
        .busy(busy), .done(done), .err(err), .pe_lo(pe_lo), .pe_hi(pe_hi),
        .intra(intra), .round_idx(round_idx)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Launch one request and wait for done. Samples at negedges.
    task automatic issue(input int p, input int n, input int id, input bit poke_busy);
        int waited = 0;
        @(negedge clk);
        pe_count = W'(p); neuron_count = W'(n); neuron_id = W'(id); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 busy after start", int'(busy), 1);
        if (poke_busy) begin
            pe_count = 8'd8; neuron_count = 8'd3; neuron_id = 8'd0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done && waited < 40 * W) begin
            chk("R2 busy until done", int'(busy), 1);
            @(negedge clk);
            waited++;
        end
        chk("R2 done reached", int'(done), 1);
        chk("R2 busy low at done", int'(busy), 0);
    endtask

    task automatic expect_ok(input int p, input int n, input int id, input bit poke_busy);
        int q, r, s, lo, hi, slot;
        string tag;
        q = n / p; r = n % p; slot = id % p;
        if (id < q * p) begin lo = slot; hi = slot; tag = "R3"; end
        else begin s = p / r; lo = slot * s; hi = lo + s - 1; tag = "R4"; end
        issue(p, n, id, poke_busy);
        chk($sformatf("%s lo p=%0d n=%0d id=%0d", tag, p, n, id), int'(pe_lo), lo);
        chk($sformatf("%s hi p=%0d n=%0d id=%0d", tag, p, n, id), int'(pe_hi), hi);
        chk($sformatf("R5 intra p=%0d n=%0d id=%0d", p, n, id), int'(intra), int'(hi > lo));
        chk($sformatf("R6 round p=%0d n=%0d id=%0d", p, n, id), int'(round_idx), id / p);
        chk("R8 err clear on good request", int'(err), 0);
        @(negedge clk);
        chk("R2 done single pulse", int'(done), 0);
    endtask

    task automatic t_reset();
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 err", int'(err), 0);
        chk("R1 intra", int'(intra), 0);
        chk("R1 lo", int'(pe_lo), 0);
        chk("R1 hi", int'(pe_hi), 0);
        chk("R1 round", int'(round_idx), 0);
    endtask

    task automatic t_layer(input int p, input int n);
        for (int id = 0; id < n; id++) expect_ok(p, n, id, 1'b0);
    endtask

    task automatic t_multiple_r7();
        for (int id = 0; id < 16; id++) begin
            expect_ok(8, 16, id, 1'b0);
            chk("R7 single PE", int'(pe_hi == pe_lo), 1);
        end
    endtask

    task automatic t_faults_r8();
        int cases [3][3] = '{'{0, 5, 0}, '{8, 0, 0}, '{8, 4, 4}};
        for (int k = 0; k < 3; k++) begin
            expect_ok(8, 9, 8, 1'b0);
            issue(cases[k][0], cases[k][1], cases[k][2], 1'b0);
            chk("R8 err", int'(err), 1);
            chk("R8 lo zero", int'(pe_lo), 0);
            chk("R8 hi zero", int'(pe_hi), 0);
            chk("R8 intra zero", int'(intra), 0);
            chk("R8 round zero", int'(round_idx), 0);
        end
        expect_ok(8, 3, 2, 1'b0);
    endtask

    task automatic t_busy_ignore_r9();
        expect_ok(8, 9, 8, 1'b1);
        chk("R9 second start ignored, no extra done", int'(busy), 0);
        repeat (4 * W) begin
            chk("R9 no second result", int'(done), 0);
            @(negedge clk);
        end
    endtask

    task automatic t_hold_r10();
        logic [W-1:0] lo0, hi0, rd0;
        expect_ok(7, 3, 1, 1'b0);
        lo0 = pe_lo; hi0 = pe_hi; rd0 = round_idx;
        pe_count = 8'd1; neuron_count = 8'd1; neuron_id = 8'd0;
        repeat (6) @(negedge clk);
        chk("R10 lo held", int'(pe_lo), int'(lo0));
        chk("R10 hi held", int'(pe_hi), int'(hi0));
        chk("R10 round held", int'(round_idx), int'(rd0));
    endtask

    initial begin
        #200000;
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layer(8, 9);     // R3 then R4: last neuron uses all PEs
        t_layer(8, 3);     // R4: two PEs each, two idle
        t_layer(8, 4);     // R4: two PEs each
        t_layer(8, 5);     // R4/R5: slice width 1, no split
        t_layer(8, 20);    // R3, R4 over rounds, R6
        t_layer(7, 3);     // R4: odd PE count, one idle
        t_multiple_r7();
        t_faults_r8();
        t_busy_ignore_r9();
        t_hold_r10();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule